// File: doc/BRIEF.md
# Memory protection entry configuration bank

This block stores the settings of eight physical memory protection entries and makes them reachable through a plain CSR read/write port (address, write enable, write data, read data). Each entry owns one 32-bit address word and one 8-bit configuration byte. The configuration bytes are packed four to a 32-bit CSR word. The block also presents every stored byte and word, flattened, to the permission checker that sits next to it.

Every configuration byte carries a lock flag. Once the lock flag is set, it freezes the entry against later software writes until the next reset. When a locked entry uses top-of-range matching, the lock also freezes the address word of the entry just below it, because that word is the locked region's lower bound. Reserved bits are never stored. Reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `pmp_cfg_bank`

## Requirements
- R1: During and after reset every configuration byte and every address word is zero, so all entries are unlocked and their mode field is 00 (off).
- R2: The address word of entry i sits at CSR address 0x3B0+i (i = 0..7), holds 32 bits and reads back the last value accepted. addr_o bits 32i+31:32i carry it.
- R3: Configuration word 0x3A0 packs entries 0..3 and word 0x3A1 packs entries 4..7. Entry 4k+j occupies bits 8j+7:8j of word k. cfg_o bits 8i+7:8i carry entry i.
- R4: Within a configuration byte, bit 7 is the lock, bits 4:3 the mode (01 = top of range), and bits 2:0 the X/W/R permissions. Bits 6:5 always read zero, whatever value was written.
- R5: A write to a configuration word leaves the bytes of locked entries unchanged and updates the bytes of unlocked entries in that same word.
- R6: Writes to the address word of a locked entry are ignored.
- R7: If entry i+1 is locked and its mode is 01, writes to the address word of entry i are ignored. A locked entry i+1 in any other mode does not block entry i.
- R8: A read of any CSR address outside 0x3A0..0x3A1 and 0x3B0..0x3B7 returns zero, and a write to such an address changes no state.
- R9: With the write enable low, no state changes.
- R10: Software writes can never clear a lock bit. Only reset clears it, after which the entry accepts writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data, combinational |
| cfg_o | output | 64 | Configuration bytes, entry i at bits 8i+7:8i |
| addr_o | output | 256 | Address words, entry i at bits 32i+31:32i |

## Verification
Two functions can fall in the same cycle. A single packed configuration write must at once mask the reserved bits of the open bytes and leave alone the bytes that are already locked. The bench provokes this with words that mix locked and unlocked entries and that set reserved bits in every byte. A locked top-of-range entry also blocks its lower neighbour's address word, so one address write is judged against two lock sources. Every result is compared with a bench-side model built from the requirements, both through CSR reads and on the flat cfg_o/addr_o outputs.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] CFG_BASE  = 12'h3A0;
  localparam logic [CSR_AW-1:0] ADDR_BASE = 12'h3B0;
  localparam logic [1:0] MODE_TOR = 2'b01;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  function automatic cfg_t cfg_clean(logic [7:0] raw);
    cfg_t c;
    c = cfg_t'(raw);
    c.rsvd = 2'b00;
    return c;
  endfunction
endpackage

// File: rtl/pmp_cfg_decode.sv
module pmp_cfg_decode
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned CFG_WORDS = 2
) (
  input  logic [CSR_AW-1:0]    csr_addr_i,
  output logic [CFG_WORDS-1:0] cfg_sel_o,
  output logic [N_ENTRIES-1:0] addr_sel_o
);
  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
    assign cfg_sel_o[k] = (csr_addr_i == CFG_BASE + CSR_AW'(k));
  end
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_addr
    assign addr_sel_o[i] = (csr_addr_i == ADDR_BASE + CSR_AW'(i));
  end
endmodule

// File: rtl/pmp_cfg_entry.sv
module pmp_cfg_entry
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              addr_we_i,
  input  logic [DATA_W-1:0] addr_wdata_i,
  input  logic              upper_tor_lock_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] addr_o,
  output logic              tor_lock_o
);
  cfg_t              cfg_q;
  logic [DATA_W-1:0] addr_q;
  logic              addr_frozen;

  // upper neighbour's locked TOR range uses this word as its base
  assign addr_frozen = cfg_q.lock | upper_tor_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_we_i && !cfg_q.lock) cfg_q <= cfg_clean(cfg_wdata_i);
      if (addr_we_i && !addr_frozen) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o      = cfg_q;
  assign addr_o     = addr_q;
  assign tor_lock_o = cfg_q.lock && (cfg_q.mode == MODE_TOR);
endmodule

// File: rtl/pmp_cfg_rdata.sv
module pmp_cfg_rdata #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CFG_WORDS = 2
) (
  input  logic [CFG_WORDS-1:0]        cfg_sel_i,
  input  logic [N_ENTRIES-1:0]        addr_sel_i,
  input  logic [N_ENTRIES*8-1:0]      cfg_i,
  input  logic [N_ENTRIES*DATA_W-1:0] addr_i,
  output logic [DATA_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < CFG_WORDS; k++)
      if (cfg_sel_i[k]) rdata_o = cfg_i[k*DATA_W +: DATA_W];
    for (int i = 0; i < N_ENTRIES; i++)
      if (addr_sel_i[i]) rdata_o = addr_i[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CSR_AW-1:0]           csr_addr_i,
  input  logic                        csr_we_i,
  input  logic [DATA_W-1:0]           csr_wdata_i,
  output logic [DATA_W-1:0]           csr_rdata_o,
  output logic [N_ENTRIES*8-1:0]      cfg_o,
  output logic [N_ENTRIES*DATA_W-1:0] addr_o
);
  localparam int unsigned CFG_PER_WORD = DATA_W / 8;
  localparam int unsigned CFG_WORDS    = N_ENTRIES / CFG_PER_WORD;

  logic [CFG_WORDS-1:0] cfg_sel;
  logic [N_ENTRIES-1:0] addr_sel;
  logic [N_ENTRIES:0]   tor_lock;

  assign tor_lock[N_ENTRIES] = 1'b0;

  pmp_cfg_decode #(.N_ENTRIES(N_ENTRIES), .CFG_WORDS(CFG_WORDS)) u_decode (
    .csr_addr_i (csr_addr_i),
    .cfg_sel_o  (cfg_sel),
    .addr_sel_o (addr_sel)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    cfg_t cfg_e;
    pmp_cfg_entry #(.DATA_W(DATA_W)) u_entry (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .cfg_we_i         (csr_we_i & cfg_sel[i/CFG_PER_WORD]),
      .cfg_wdata_i      (csr_wdata_i[(i%CFG_PER_WORD)*8 +: 8]),
      .addr_we_i        (csr_we_i & addr_sel[i]),
      .addr_wdata_i     (csr_wdata_i),
      .upper_tor_lock_i (tor_lock[i+1]),
      .cfg_o            (cfg_e),
      .addr_o           (addr_o[i*DATA_W +: DATA_W]),
      .tor_lock_o       (tor_lock[i])
    );
    assign cfg_o[i*8 +: 8] = cfg_e;
  end

  pmp_cfg_rdata #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS)) u_rdata (
    .cfg_sel_i  (cfg_sel),
    .addr_sel_i (addr_sel),
    .cfg_i      (cfg_o),
    .addr_i     (addr_o),
    .rdata_o    (csr_rdata_o)
  );
endmodule

// File: rtl/pmp_cfg_bank_chk.sv
module pmp_cfg_bank_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned DATA_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        csr_we_i,
  input logic [N_ENTRIES*8-1:0]      cfg_o,
  input logic [N_ENTRIES*DATA_W-1:0] addr_o
);
  // R1: state is zero on the first edge after reset release
  a_r1_reset_zero: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cfg_o == '0 && addr_o == '0));

  // R9
  a_r9_no_we_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> ($stable(cfg_o) && $stable(addr_o)));

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_e
    // R4
    a_r4_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[i*8+6 -: 2] == 2'b00);
    // R5 and R10
    a_r5_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[i*8+7] |=> $stable(cfg_o[i*8 +: 8]));
    // R6
    a_r6_addr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[i*8+7] |=> $stable(addr_o[i*DATA_W +: DATA_W]));
  end

  for (genvar i = 0; i + 1 < N_ENTRIES; i++) begin : g_t
    // R7
    a_r7_tor_base_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_o[(i+1)*8+7] && cfg_o[(i+1)*8+4 -: 2] == 2'b01)
        |=> $stable(addr_o[i*DATA_W +: DATA_W]));
  end
endmodule

bind pmp_cfg_bank pmp_cfg_bank_chk #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csr_we_i (csr_we_i),
  .cfg_o    (cfg_o),
  .addr_o   (addr_o)
);

// File: tb/tb_pmp_cfg_bank.sv
module tb_pmp_cfg_bank;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [11:0]  csr_addr_i = '0;
  logic         csr_we_i = 1'b0;
  logic [31:0]  csr_wdata_i = '0;
  logic [31:0]  csr_rdata_o;
  logic [63:0]  cfg_o;
  logic [255:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_cfg  [8];
  logic [31:0] m_addr [8];

  always #5 clk_i = ~clk_i;

  pmp_cfg_bank dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .csr_addr_i(csr_addr_i), .csr_we_i(csr_we_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .cfg_o(cfg_o), .addr_o(addr_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == 12'h3A0 || a == 12'h3A1) begin
      int k = int'(a[0]);
      return {m_cfg[4*k+3], m_cfg[4*k+2], m_cfg[4*k+1], m_cfg[4*k]};
    end
    if (a >= 12'h3B0 && a <= 12'h3B7) return m_addr[a[2:0]];
    return '0;
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    if (a == 12'h3A0 || a == 12'h3A1) begin
      for (int j = 0; j < 4; j++) begin
        int e = int'(a[0]) * 4 + j;
        if (!m_cfg[e][7]) m_cfg[e] = d[8*j +: 8] & 8'h9F;
      end
    end else if (a >= 12'h3B0 && a <= 12'h3B7) begin
      int i = int'(a[2:0]);
      bit blk = m_cfg[i][7];
      if (i < 7 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'b01) blk = 1;
      if (!blk) m_addr[i] = d;
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
    m_write(a, d);
    @(negedge clk_i);
    csr_we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    @(negedge clk_i);
    csr_addr_i = a; csr_we_i = 1'b0;
    #1;
    chk(req, csr_rdata_o, m_read(a));
  endtask

  task automatic all_chk(string req);
    for (int i = 0; i < 2; i++) rd_chk(req, 12'h3A0 + 12'(i));
    for (int i = 0; i < 8; i++) rd_chk(req, 12'h3B0 + 12'(i));
    for (int i = 0; i < 8; i++) begin
      chk({req, " cfg_o"}, {24'h0, cfg_o[8*i +: 8]}, {24'h0, m_cfg[i]});
      chk({req, " addr_o"}, addr_o[32*i +: 32], m_addr[i]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_reset();
    #1;
    chk("R1 async cfg", {31'h0, cfg_o != '0}, 32'h0);
    chk("R1 async addr", {31'h0, addr_o != '0}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    all_chk("R1");

    // R2: address words
    for (int i = 0; i < 8; i++) wr(12'h3B0 + 12'(i), 32'hA5A5_0000 ^ (32'h1111_1111 * (i + 1)));
    all_chk("R2");
    for (int i = 0; i < 8; i++) wr(12'h3B0 + 12'(i), ~(32'h0101_0101 << i));
    all_chk("R2");

    // R3/R4: every byte value without lock, in each lane of both words
    for (int v = 0; v < 128; v++) begin
      wr(12'h3A0, {8'(v), 8'(v ^ 8'h55), 8'(v ^ 8'h2A), 8'(127 - v)});
      wr(12'h3A1, {8'(127 - v), 8'(v), 8'(v ^ 8'h60), 8'(v ^ 8'h1F)});
      rd_chk("R4", 12'h3A0);
      rd_chk("R3", 12'h3A1);
    end
    wr(12'h3A0, 32'h1C1B_0A09);
    wr(12'h3A1, 32'h0403_0201);
    all_chk("R3");

    // R8: unmapped space, read zero, no write effect
    for (int a = 12'h380; a < 12'h3D0; a++) begin
      if (a == 12'h3A0 || a == 12'h3A1 || (a >= 12'h3B0 && a <= 12'h3B7)) continue;
      wr(12'(a), 32'hFFFF_FFFF);
      rd_chk("R8", 12'(a));
    end
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hFFF, 32'hFFFF_FFFF);
    all_chk("R8");

    // R9: enable low
    @(negedge clk_i);
    csr_addr_i = 12'h3A0; csr_wdata_i = 32'h9F9F_9F9F; csr_we_i = 1'b0;
    @(negedge clk_i);
    csr_addr_i = 12'h3B3;
    @(negedge clk_i);
    all_chk("R9");

    // R5/R6/R7: word 0 locks entry1 (TOR) and entry2 (NAPOT), reserved bits set
    wr(12'h3A0, 32'h61FF_E9E5);
    all_chk("R4 lock write");
    wr(12'h3A0, 32'h1111_1111);
    all_chk("R5");
    for (int i = 0; i < 4; i++) wr(12'h3B0 + 12'(i), 32'hC0DE_0000 + i);
    all_chk("R6 R7");
    // word 1: entry5 locked NA4 (no base lock), entry7 locked TOR
    wr(12'h3A1, 32'h8F07_9000);
    for (int i = 4; i < 8; i++) wr(12'h3B0 + 12'(i), 32'hBEEF_0000 + i);
    all_chk("R7");
    chk("R7 addr4 open", addr_o[4*32 +: 32], 32'hBEEF_0004);
    chk("R7 addr6 frozen", {31'h0, addr_o[6*32 +: 32] == 32'hBEEF_0006}, 32'h0);

    // R10: locks survive clearing writes
    wr(12'h3A0, 32'h0);
    wr(12'h3A1, 32'h0);
    all_chk("R10");
    chk("R10 lock1", {31'h0, cfg_o[15]}, 32'h1);
    chk("R10 lock7", {31'h0, cfg_o[63]}, 32'h1);

    do_reset();
    all_chk("R10 R1");
    wr(12'h3A0, 32'h0403_0201);
    wr(12'h3B1, 32'h1234_5678);
    all_chk("R10 reopen");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule